// File: doc/BRIEF.md
# TRNG Oscillator Frequency Monitor

This block watches the free-running oscillator that feeds a true random number generator and flags it when its rate drifts out of a safe band. The oscillator output is brought into the system clock domain, and its rising edges are counted over a window. The window length in system clock cycles is set by a programmable entropy delay. When each window closes, the edge count is frozen into a readable register and compared against programmable lower and upper limits. A count outside the limits raises a sticky error flag. A count inside them, with no error pending, marks the entropy source valid.

Software works the block through a small word-addressed register port. The block comes out of reset in program mode. Configuration can be changed only in that mode. Clearing the program bit starts monitoring. Setting the program bit together with the access bit throws away the current entropy sample, so a fresh good window has to pass after the return to run mode before the source counts as valid again. A common setting puts the lower limit at one quarter of the entropy delay and the upper limit at sixteen times it. The reset values follow that setting.

Top module: `ent_freq_mon`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x1 (program mode on, all other bits 0), DELAY (address 1) reads 64, FMIN (address 2) reads 16, FMAX (address 3) reads 1024, COUNT (address 4) reads 0, and both `ent_err` and `ent_valid` are low.
- R2: A write to DELAY, FMIN or FMAX, or to the CTRL sample-mode field, takes effect only if the program bit (CTRL bit 0) is set when the write happens. In run mode such writes leave the stored value unchanged.
- R3: A DELAY write whose full 32-bit value lies outside 16..3200 is rejected and the previous delay is kept. The values 16 and 3200 themselves are accepted.
- R4: FMIN and FMAX keep the low 22 bits of the written word and read those bits back exactly. The 2-bit sample-mode field at CTRL bits 4:3 reads back exactly as written.
- R5: In run mode, COUNT holds the number of rising edges of `samp_clk` seen in the most recent window, where a window is DELAY system clock cycles long.
- R6: At the end of a window, a count below FMIN or above FMAX sets the error flag (CTRL bit 2, `ent_err`). A count equal to either limit does not.
- R7: The error flag stays set until a CTRL write with bit 2 equal to 1. A CTRL write with bit 2 equal to 0, or later in-range windows, leave it set.
- R8: The valid flag (CTRL bit 8, `ent_valid`) stays low until the first in-range window ends after entering run mode with no error pending. It is low whenever the error flag is set.
- R9: While the program and access bits (CTRL bit 1) are both set, the valid flag is cleared. Setting the program bit alone leaves the valid flag unchanged.
- R10: In program mode, window counting stops: COUNT holds its value and no error is raised, whatever `samp_clk` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_clk | input | 1 | Free-running entropy oscillator, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Register word address (0 CTRL, 1 DELAY, 2 FMIN, 3 FMAX, 4 COUNT) |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data of the addressed register, combinational |
| ent_err | output | 1 | Sticky frequency error flag |
| ent_valid | output | 1 | Entropy sample valid flag |

## Verification
The oscillator is swept through half-periods of 1, 2, 3, 4, 6 and 8 system cycles against a 48-cycle window. Each setting gives an exact edge count of 48 divided by the period, which the bench computes. The limits are set to 4 and 12, so the sweep covers a count too high, a count equal to the upper limit, two counts inside the band, a count equal to the lower limit, and a count too low. This separates the less-than and greater-than comparisons from off-by-one boundary mistakes. Further sequences mix program and run mode writes, out-of-range delays, a good oscillator after an error, and program mode with and without the access bit. These separate the write-lock, the rejection of bad delays, error stickiness and sample invalidation.

// File: rtl/ent_freq_mon_pkg.sv
package ent_freq_mon_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_DELAY = 3'd1,
        REG_FMIN  = 3'd2,
        REG_FMAX  = 3'd3,
        REG_COUNT = 3'd4
    } reg_addr_e;

    localparam int CTRL_PROG   = 0;
    localparam int CTRL_ACC    = 1;
    localparam int CTRL_ERR    = 2;
    localparam int CTRL_MODE   = 3;
    localparam int MODE_W      = 2;
    localparam int CTRL_VALID  = 8;
endpackage

// File: rtl/ent_samp_sync.sv
module ent_samp_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_async,
    output logic rise
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], samp_async};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        rise      = st_q.sync[SYNC_STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    rise_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ent_win_counter.sv
module ent_win_counter #(
    parameter int DLY_W = 16,
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DLY_W-1:0] dly,
    input  logic             rise,
    output logic             freeze,
    output logic [CNT_W-1:0] sample_cnt
);
    typedef struct packed {
        logic [DLY_W-1:0] win;
        logic [CNT_W-1:0] edges;
    } win_state_t;

    win_state_t st_d, st_q;
    logic [CNT_W-1:0] edge_sum;
    logic             last;

    always_comb begin
        st_d     = st_q;
        edge_sum = st_q.edges + CNT_W'(rise);
        last     = run && (st_q.win == dly - 1'b1);
        if (!run) begin
            st_d.win   = '0;
            st_d.edges = '0;
        end else if (last) begin
            st_d.win   = '0;
            st_d.edges = '0;
        end else begin
            st_d.win   = st_q.win + 1'b1;
            st_d.edges = edge_sum;
        end
        freeze     = last;
        sample_cnt = edge_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.win < dly));

    // R5
    edge_le_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(st_q.win) >= st_q.edges);
endmodule

// File: rtl/ent_cfg_regs.sv
module ent_cfg_regs
    import ent_freq_mon_pkg::*;
#(
    parameter int DLY_W   = 16,
    parameter int LIM_W   = 22,
    parameter int DLY_MIN = 16,
    parameter int DLY_MAX = 3200,
    parameter int DLY_RST = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              freeze,
    input  logic [LIM_W-1:0]  sample_cnt,
    output logic [31:0]       rdata,
    output logic              run,
    output logic [DLY_W-1:0]  dly,
    output logic              err,
    output logic              valid
);
    localparam int FMIN_RST = DLY_RST / 4;
    localparam int FMAX_RST = DLY_RST * 16;

    typedef struct packed {
        logic              prog;
        logic              acc;
        logic [MODE_W-1:0] mode;
        logic              err;
        logic              valid;
        logic [DLY_W-1:0]  dly;
        logic [LIM_W-1:0]  fmin;
        logic [LIM_W-1:0]  fmax;
        logic [LIM_W-1:0]  cnt;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic wr_ctrl, wr_dly, wr_fmin, wr_fmax;
    logic dly_in_range, out_of_band, err_set;

    always_comb begin
        st_d         = st_q;
        wr_ctrl      = wr_en && (addr == REG_CTRL);
        wr_dly       = wr_en && (addr == REG_DELAY);
        wr_fmin      = wr_en && (addr == REG_FMIN);
        wr_fmax      = wr_en && (addr == REG_FMAX);
        dly_in_range = (wdata >= 32'(DLY_MIN)) && (wdata <= 32'(DLY_MAX));
        out_of_band  = (sample_cnt < st_q.fmin) || (sample_cnt > st_q.fmax);
        err_set      = freeze && !st_q.prog && out_of_band;

        if (wr_ctrl) begin
            st_d.prog = wdata[CTRL_PROG];
            st_d.acc  = wdata[CTRL_ACC];
            if (st_q.prog) st_d.mode = wdata[CTRL_MODE +: MODE_W];
        end
        if (wr_dly && st_q.prog && dly_in_range) st_d.dly  = wdata[DLY_W-1:0];
        if (wr_fmin && st_q.prog)                st_d.fmin = wdata[LIM_W-1:0];
        if (wr_fmax && st_q.prog)                st_d.fmax = wdata[LIM_W-1:0];

        if (wr_ctrl && wdata[CTRL_ERR]) st_d.err = 1'b0;
        if (err_set)                    st_d.err = 1'b1;

        if (freeze && !st_q.prog) st_d.cnt = sample_cnt;

        if (st_q.prog && st_q.acc)    st_d.valid = 1'b0;
        else if (err_set || st_q.err) st_d.valid = 1'b0;
        else if (freeze)              st_d.valid = 1'b1;

        rdata = '0;
        case (addr)
            REG_CTRL: begin
                rdata[CTRL_PROG]             = st_q.prog;
                rdata[CTRL_ACC]              = st_q.acc;
                rdata[CTRL_ERR]              = st_q.err;
                rdata[CTRL_MODE +: MODE_W]   = st_q.mode;
                rdata[CTRL_VALID]            = st_q.valid;
            end
            REG_DELAY: rdata[DLY_W-1:0] = st_q.dly;
            REG_FMIN:  rdata[LIM_W-1:0] = st_q.fmin;
            REG_FMAX:  rdata[LIM_W-1:0] = st_q.fmax;
            REG_COUNT: rdata[LIM_W-1:0] = st_q.cnt;
            default:   rdata = '0;
        endcase

        run   = !st_q.prog;
        dly   = st_q.dly;
        err   = st_q.err;
        valid = st_q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.prog  <= 1'b1;
            st_q.dly   <= DLY_W'(DLY_RST);
            st_q.fmin  <= LIM_W'(FMIN_RST);
            st_q.fmax  <= LIM_W'(FMAX_RST);
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !st_q.prog && (addr != REG_CTRL)) |=>
            ($stable(st_q.dly) && $stable(st_q.fmin) && $stable(st_q.fmax)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.prog) |=> $stable(st_q.mode));

    // R3
    dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dly >= DLY_W'(DLY_MIN)) && (st_q.dly <= DLY_W'(DLY_MAX)));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !(wr_en && (addr == REG_CTRL) && wdata[CTRL_ERR])) |=> st_q.err);

    // R8
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.valid && st_q.err));

    // R9
    inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prog && st_q.acc) |=> !st_q.valid);

    // R10
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.prog |-> !freeze);
endmodule

// File: rtl/ent_freq_mon.sv
module ent_freq_mon
    import ent_freq_mon_pkg::*;
#(
    parameter int DLY_W       = 16,
    parameter int LIM_W       = 22,
    parameter int DLY_MIN     = 16,
    parameter int DLY_MAX     = 3200,
    parameter int DLY_RST     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              ent_err,
    output logic              ent_valid
);
    logic             rise;
    logic             run;
    logic             freeze;
    logic [DLY_W-1:0] dly;
    logic [LIM_W-1:0] sample_cnt;

    ent_samp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_async (samp_clk),
        .rise       (rise)
    );

    ent_win_counter #(.DLY_W(DLY_W), .CNT_W(LIM_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .dly        (dly),
        .rise       (rise),
        .freeze     (freeze),
        .sample_cnt (sample_cnt)
    );

    ent_cfg_regs #(
        .DLY_W   (DLY_W),
        .LIM_W   (LIM_W),
        .DLY_MIN (DLY_MIN),
        .DLY_MAX (DLY_MAX),
        .DLY_RST (DLY_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .freeze     (freeze),
        .sample_cnt (sample_cnt),
        .rdata      (rdata),
        .run        (run),
        .dly        (dly),
        .err        (ent_err),
        .valid      (ent_valid)
    );
endmodule

// File: tb/ent_freq_mon_tb.sv
module ent_freq_mon_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        samp_clk = 0;
    logic        wr_en = 0;
    logic [2:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        ent_err, ent_valid;

    int checks = 0;
    int fails  = 0;
    int half   = 4;

    ent_freq_mon u_dut (
        .clk(clk), .rst_n(rst_n), .samp_clk(samp_clk), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .ent_err(ent_err), .ent_valid(ent_valid)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            repeat (half) @(negedge clk);
            samp_clk = ~samp_clk;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        int hs[6] = '{1, 2, 3, 4, 6, 8};
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(0, v); check("R1 ctrl", v, 32'h1);
        rd(1, v); check("R1 delay", v, 64);
        rd(2, v); check("R1 fmin", v, 16);
        rd(3, v); check("R1 fmax", v, 1024);
        rd(4, v); check("R1 count", v, 0);
        check("R1 pins", {ent_err, ent_valid}, 0);

        // R4 exact read-back
        wr(2, 32'hFFFF_FFFF); rd(2, v); check("R4 fmin mask", v, 32'h3F_FFFF);
        wr(3, 32'h002A_AAAA); rd(3, v); check("R4 fmax", v, 32'h2A_AAAA);
        wr(0, 32'h11); rd(0, v); check("R4 mode 10", v, 32'h11);
        wr(0, 32'h09); rd(0, v); check("R4 mode 01", v, 32'h09);

        // R3 delay range
        wr(1, 15);          rd(1, v); check("R3 below min", v, 64);
        wr(1, 3201);        rd(1, v); check("R3 above max", v, 64);
        wr(1, 32'h1_0010);  rd(1, v); check("R3 high bits", v, 64);
        wr(1, 16);          rd(1, v); check("R3 min ok", v, 16);
        wr(1, 3200);        rd(1, v); check("R3 max ok", v, 3200);
        wr(1, 48);          rd(1, v); check("R3 set 48", v, 48);
        wr(2, 4); wr(3, 12);

        // R5 R6 R8 oscillator sweep
        for (int i = 0; i < 6; i++) begin
            int exp_cnt;
            logic bad;
            half = hs[i];
            exp_cnt = 48 / (2 * hs[i]);
            bad = (exp_cnt < 4) || (exp_cnt > 12);
            wr(0, 32'h0F);
            repeat (20) @(negedge clk);
            wr(0, 32'h08);
            repeat (40) @(negedge clk);
            check("R8 valid before first window", ent_valid, 0);
            repeat (160) @(negedge clk);
            rd(4, v); check("R5 window count", v, exp_cnt);
            check("R6 err vs limits", ent_err, bad);
            check("R8 valid after window", ent_valid, !bad);
        end

        // R7 stickiness: now errored, good oscillator
        half = 4;
        repeat (200) @(negedge clk);
        check("R7 err sticky", ent_err, 1);
        check("R8 valid low with err", ent_valid, 0);
        wr(0, 32'h08);
        check("R7 write zero keeps err", ent_err, 1);
        wr(0, 32'h0C);
        check("R7 w1c clears", ent_err, 0);
        repeat (120) @(negedge clk);
        check("R8 valid after clear", ent_valid, 1);
        check("R6 no err at 6", ent_err, 0);

        // R2 run-mode writes ignored
        wr(1, 100); rd(1, v); check("R2 delay locked", v, 48);
        wr(2, 7);   rd(2, v); check("R2 fmin locked", v, 4);
        wr(3, 9);   rd(3, v); check("R2 fmax locked", v, 12);
        wr(0, 32'h10); rd(0, v); check("R2 mode locked", v, 32'h108);

        // R9 invalidation
        wr(0, 32'h09); rd(0, v); check("R9 prog alone keeps valid", v, 32'h109);
        wr(0, 32'h0B); rd(0, v); check("R9 prog+acc invalidates", v, 32'h00B);
        check("R9 valid pin", ent_valid, 0);

        // R10 program mode halts monitoring
        half = 1;
        repeat (200) @(negedge clk);
        rd(4, v); check("R10 count held", v, 6);
        check("R10 no err in prog", ent_err, 0);

        summary();
    end
endmodule